// File: doc/BRIEF.md
# Register Rename Map and Free List

This block sits in the decode stage of an out-of-order core and renames a group of up to NW instructions every cycle. It holds a speculative map from architectural register numbers to physical register numbers and a FIFO of unused physical registers. For each instruction in the group it returns the physical numbers of both sources and a freshly allocated destination. It also reports the physical register that the destination held before, so that register can be released when the instruction retires. Integer and floating-point architectural registers share one index space (for example 0..7 integer, 8..15 floating point) and one pool of NPHYS physical registers. Index 0 is the hardwired zero register and is never renamed.

Instructions inside one group may depend on each other. A source or an overwritten destination that names a register written by an earlier slot of the same group takes that slot's new physical register. When the free list cannot serve every destination, the longest fully served prefix of the group is accepted and the rest must be presented again. Retiring instructions update a second, retirement-state copy of the map and return their old physical registers to the tail of the free list. A flush copies the retirement map over the speculative map and rebuilds the free list from the registers that copy does not reference.

Top module: `reg_renamer`

## Requirements
- R1: A source whose architectural number is not the destination of an earlier accepted slot of the same group is given the speculative map entry as it stood at the start of the cycle.
- R2: A source, or the previous-mapping output, whose architectural number matches the destination of one or more earlier accepted slots of the group takes the new physical register of the latest such slot.
- R3: Accepted slots that need a destination receive physical registers from the head of the free list in slot order, and the map holds them from the next cycle on; a slot that needs no destination reports 0 as new and previous register.
- R4: For each accepted slot with a destination, the previous-mapping output equals the physical register that the architectural destination mapped to just before that slot.
- R5: Architectural index 0 always reads as physical 0, a destination of 0 allocates nothing, and both of its register outputs are 0.
- R6: Bit i of the accept mask is 1 only when slots 0..i are all valid and the number of destinations they need does not exceed the free-list occupancy at the start of the cycle; the mask is therefore always a prefix (ones from bit 0 upward).
- R7: Each valid retire slot appends its freed physical register at the tail of the free list, in slot order, and that register may be handed out from the next cycle on, after all registers already queued.
- R8: Each valid retire slot writes its architectural/physical pair into the retirement map, a later slot winning. While flush is high no slot is accepted and retire inputs are ignored; after the flush edge the speculative map equals the retirement map and the free list holds every physical register not referenced by it, except 0, in ascending order.
- R9: After reset, architectural register a maps to physical register a, and the free list holds physical registers NARCH to NPHYS-1 in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Restore the retirement map and rebuild the free list |
| ren_vld | input | NW | Slot valid for the rename group |
| ren_src1 | input | NW*AW | First source architectural number per slot |
| ren_src2 | input | NW*AW | Second source architectural number per slot |
| ren_dst | input | NW*AW | Destination architectural number per slot |
| ren_dst_en | input | NW | Slot writes a destination |
| ren_ok | output | NW | Accepted slots (prefix mask) |
| ren_psrc1 | output | NW*PW | Physical first source per slot |
| ren_psrc2 | output | NW*PW | Physical second source per slot |
| ren_pdst | output | NW*PW | Newly allocated physical destination, 0 if none |
| ren_pold | output | NW*PW | Previous physical mapping of the destination, 0 if none |
| ret_vld | input | NB | Retire slot valid |
| ret_arch | input | NB*AW | Architectural destination of the retiring instruction |
| ret_preg | input | NB*PW | Physical register it now commits to |
| ret_free | input | NB*PW | Physical register released to the free list (0 ignored) |

## Verification
The group renamer is driven with many random groups drawn from a tiny register window (numbers 0..3). These force same-group read-after-write, write-after-write and zero-register cases, and separate the table lookup from in-group forwarding. Wider windows with holes in the valid mask exercise the prefix rule for invalid slots. Phases where retirement is throttled to one register per cycle drain the free list, so the accept mask is checked against the occupancy bound and recycled registers are checked for FIFO order. Flushes are issued with live retire inputs, and a reset sweep walks every architectural number as a source and checks the first allocations.

// File: rtl/rn_pkg.sv
package rn_pkg;
  // Index of the element that lies off places beyond base in a ring of depth entries
  function automatic int ring_slot(int base, int off, int depth);
    return (base + off) % depth;
  endfunction
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int NPHYS = 32,
  parameter int NARCH = 16,
  parameter int NW    = 4,
  parameter int NB    = 4,
  localparam int PW = $clog2(NPHYS),
  localparam int CW = $clog2(NPHYS + 1),
  localparam int WC = $clog2(NW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [NPHYS-1:0] busy_mask,
  input  logic [WC-1:0]    pop_cnt,
  input  logic [NB-1:0]    push_vld,
  input  logic [NB*PW-1:0] push_preg,
  output logic [NW*PW-1:0] peek,
  output logic [CW-1:0]    count
);
  logic [PW-1:0] slots_q [NPHYS];
  logic [PW-1:0] slots_d [NPHYS];
  logic [PW-1:0] head_q, head_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] push_n;

  assign count = cnt_q;

  always_comb begin
    for (int k = 0; k < NW; k++)
      peek[k*PW +: PW] = slots_q[PW'(rn_pkg::ring_slot(int'(head_q), k, NPHYS))];
  end

  always_comb begin
    int fill;
    int npush;
    slots_d = slots_q;
    head_d  = head_q;
    cnt_d   = cnt_q;
    fill    = 0;
    npush   = 0;
    if (flush) begin
      head_d = '0;
      for (int p = 0; p < NPHYS; p++) begin
        if (!busy_mask[p] && p != 0) begin
          slots_d[PW'(fill)] = PW'(p);
          fill++;
        end
      end
      cnt_d = CW'(fill);
    end else begin
      head_d = PW'(rn_pkg::ring_slot(int'(head_q), int'(pop_cnt), NPHYS));
      for (int b = 0; b < NB; b++) begin
        if (push_vld[b] && push_preg[b*PW +: PW] != '0) begin
          slots_d[PW'(rn_pkg::ring_slot(int'(head_q), int'(cnt_q) + npush, NPHYS))] =
            push_preg[b*PW +: PW];
          npush++;
        end
      end
      cnt_d = cnt_q - CW'(pop_cnt) + CW'(npush);
    end
    push_n = CW'(npush);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NPHYS; k++)
        slots_q[k] <= (k < NPHYS - NARCH) ? PW'(k + NARCH) : '0;
      head_q <= '0;
      cnt_q  <= CW'(NPHYS - NARCH);
    end else begin
      slots_q <= slots_d;
      head_q  <= head_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= NPHYS); // R7
  AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (int'(cnt_q) - int'(pop_cnt) + int'(push_n) <= NPHYS - 1)); // R7
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable #(
  parameter int NARCH = 16,
  parameter int NPHYS = 32,
  parameter int NW    = 4,
  parameter int NB    = 4,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [NW-1:0]       wr_en,
  input  logic [NW*AW-1:0]    wr_arch,
  input  logic [NW*PW-1:0]    wr_preg,
  input  logic [NB-1:0]       cm_vld,
  input  logic [NB*AW-1:0]    cm_arch,
  input  logic [NB*PW-1:0]    cm_preg,
  output logic [NARCH*PW-1:0] map_flat,
  output logic [NPHYS-1:0]    busy_mask
);
  logic [PW-1:0] spec_q [NARCH];
  logic [PW-1:0] spec_d [NARCH];
  logic [PW-1:0] ret_q  [NARCH];
  logic [PW-1:0] ret_d  [NARCH];

  always_comb begin
    spec_d = spec_q;
    ret_d  = ret_q;
    if (flush) begin
      spec_d = ret_q;
    end else begin
      for (int i = 0; i < NW; i++)
        if (wr_en[i] && wr_arch[i*AW +: AW] != '0)
          spec_d[wr_arch[i*AW +: AW]] = wr_preg[i*PW +: PW];
      for (int b = 0; b < NB; b++)
        if (cm_vld[b] && cm_arch[b*AW +: AW] != '0)
          ret_d[cm_arch[b*AW +: AW]] = cm_preg[b*PW +: PW];
    end
  end

  always_comb begin
    for (int a = 0; a < NARCH; a++) map_flat[a*PW +: PW] = spec_q[a];
  end

  always_comb begin
    busy_mask = '0;
    for (int a = 0; a < NARCH; a++) busy_mask[ret_q[a]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NARCH; a++) begin
        spec_q[a] <= PW'(a);
        ret_q[a]  <= PW'(a);
      end
    end else begin
      spec_q <= spec_d;
      ret_q  <= ret_d;
    end
  end

  AST_ZERO_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    spec_q[0] == '0 && ret_q[0] == '0); // R5
endmodule

// File: rtl/rn_group.sv
module rn_group #(
  parameter int NARCH = 16,
  parameter int NPHYS = 32,
  parameter int NW    = 4,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS),
  localparam int CW = $clog2(NPHYS + 1),
  localparam int WC = $clog2(NW + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NW-1:0]       vld,
  input  logic [NW*AW-1:0]    src1,
  input  logic [NW*AW-1:0]    src2,
  input  logic [NW*AW-1:0]    dst,
  input  logic [NW-1:0]       dst_en,
  input  logic [NARCH*PW-1:0] map_flat,
  input  logic [NW*PW-1:0]    peek,
  input  logic [CW-1:0]       free_cnt,
  output logic [NW-1:0]       ok,
  output logic [NW-1:0]       need,
  output logic [NW*PW-1:0]    psrc1,
  output logic [NW*PW-1:0]    psrc2,
  output logic [NW*PW-1:0]    pnew,
  output logic [NW*PW-1:0]    pold,
  output logic [WC-1:0]       pop_cnt
);
  logic [PW-1:0] map_a [NARCH];
  logic [PW-1:0] newp  [NW];

  always_comb begin
    for (int a = 0; a < NARCH; a++) map_a[a] = map_flat[a*PW +: PW];
  end

  // Allocation: prefix acceptance bounded by the free-list occupancy
  always_comb begin
    logic run;
    int used;
    run  = 1'b1;
    used = 0;
    for (int i = 0; i < NW; i++) begin
      need[i] = vld[i] && dst_en[i] && (dst[i*AW +: AW] != '0);
      if (!vld[i]) run = 1'b0;
      if (need[i] && used >= int'(free_cnt)) run = 1'b0;
      ok[i]   = run;
      newp[i] = need[i] ? peek[used*PW +: PW] : '0;
      if (run && need[i]) used++;
    end
    pop_cnt = WC'(used);
  end

  // Source and old-destination lookup with in-group forwarding
  always_comb begin
    logic [AW-1:0] s1, s2, d, dj;
    logic [PW-1:0] r1, r2, ro;
    for (int i = 0; i < NW; i++) begin
      s1 = src1[i*AW +: AW];
      s2 = src2[i*AW +: AW];
      d  = dst[i*AW +: AW];
      r1 = map_a[s1];
      r2 = map_a[s2];
      ro = map_a[d];
      for (int j = 0; j < i; j++) begin
        dj = dst[j*AW +: AW];
        if (need[j]) begin
          if (dj == s1) r1 = newp[j];
          if (dj == s2) r2 = newp[j];
          if (dj == d)  ro = newp[j];
        end
      end
      if (s1 == '0) r1 = '0;
      if (s2 == '0) r2 = '0;
      psrc1[i*PW +: PW] = r1;
      psrc2[i*PW +: PW] = r2;
      pnew[i*PW +: PW]  = newp[i];
      pold[i*PW +: PW]  = need[i] ? ro : '0;
    end
  end

  AST_POP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_cnt) <= int'(free_cnt)); // R6

  for (genvar g = 0; g < NW; g++) begin : g_chk
    AST_NONZERO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      (ok[g] && need[g]) |-> (pnew[g*PW +: PW] != '0)); // R3
  end
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer #(
  parameter int NARCH = 16,
  parameter int NPHYS = 32,
  parameter int NW    = 4,
  parameter int NB    = 4,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [NW-1:0]    ren_vld,
  input  logic [NW*AW-1:0] ren_src1,
  input  logic [NW*AW-1:0] ren_src2,
  input  logic [NW*AW-1:0] ren_dst,
  input  logic [NW-1:0]    ren_dst_en,
  output logic [NW-1:0]    ren_ok,
  output logic [NW*PW-1:0] ren_psrc1,
  output logic [NW*PW-1:0] ren_psrc2,
  output logic [NW*PW-1:0] ren_pdst,
  output logic [NW*PW-1:0] ren_pold,
  input  logic [NB-1:0]    ret_vld,
  input  logic [NB*AW-1:0] ret_arch,
  input  logic [NB*PW-1:0] ret_preg,
  input  logic [NB*PW-1:0] ret_free
);
  localparam int CW = $clog2(NPHYS + 1);
  localparam int WC = $clog2(NW + 1);

  logic [NW-1:0]       grp_vld;
  logic [NW-1:0]       grp_need;
  logic [NW-1:0]       map_wr;
  logic [NARCH*PW-1:0] map_flat;
  logic [NPHYS-1:0]    busy_mask;
  logic [NW*PW-1:0]    fl_peek;
  logic [CW-1:0]       fl_count;
  logic [WC-1:0]       pop_cnt;

  assign grp_vld = flush ? '0 : ren_vld;
  assign map_wr  = ren_ok & grp_need;

  rn_group #(.NARCH(NARCH), .NPHYS(NPHYS), .NW(NW)) u_group (
    .clk(clk), .rst_n(rst_n), .vld(grp_vld),
    .src1(ren_src1), .src2(ren_src2), .dst(ren_dst), .dst_en(ren_dst_en),
    .map_flat(map_flat), .peek(fl_peek), .free_cnt(fl_count),
    .ok(ren_ok), .need(grp_need),
    .psrc1(ren_psrc1), .psrc2(ren_psrc2), .pnew(ren_pdst), .pold(ren_pold),
    .pop_cnt(pop_cnt)
  );

  rn_maptable #(.NARCH(NARCH), .NPHYS(NPHYS), .NW(NW), .NB(NB)) u_map (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(map_wr), .wr_arch(ren_dst), .wr_preg(ren_pdst),
    .cm_vld(ret_vld), .cm_arch(ret_arch), .cm_preg(ret_preg),
    .map_flat(map_flat), .busy_mask(busy_mask)
  );

  rn_freelist #(.NPHYS(NPHYS), .NARCH(NARCH), .NW(NW), .NB(NB)) u_free (
    .clk(clk), .rst_n(rst_n), .flush(flush), .busy_mask(busy_mask),
    .pop_cnt(pop_cnt), .push_vld(ret_vld), .push_preg(ret_free),
    .peek(fl_peek), .count(fl_count)
  );

  AST_PREFIX_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((ren_ok + NW'(1)) & ren_ok) == '0); // R6
  AST_FLUSH_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (int'(fl_count) == NPHYS - NARCH)); // R8
endmodule

// File: tb/reg_renamer_bench.sv
module reg_renamer_bench;
  localparam int NARCH = 16;
  localparam int NPHYS = 32;
  localparam int NW = 4;
  localparam int NB = 4;
  localparam int AW = 4;
  localparam int PW = 5;

  typedef struct { int arch; int newp; int oldp; } inst_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [NW-1:0]    ren_vld = '0;
  logic [NW*AW-1:0] ren_src1 = '0, ren_src2 = '0, ren_dst = '0;
  logic [NW-1:0]    ren_dst_en = '0;
  logic [NW-1:0]    ren_ok;
  logic [NW*PW-1:0] ren_psrc1, ren_psrc2, ren_pdst, ren_pold;
  logic [NB-1:0]    ret_vld = '0;
  logic [NB*AW-1:0] ret_arch = '0;
  logic [NB*PW-1:0] ret_preg = '0, ret_free = '0;

  always #2 clk = ~clk;

  reg_renamer #(.NARCH(NARCH), .NPHYS(NPHYS), .NW(NW), .NB(NB)) u_reg_renamer (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ren_vld(ren_vld), .ren_src1(ren_src1), .ren_src2(ren_src2), .ren_dst(ren_dst),
    .ren_dst_en(ren_dst_en), .ren_ok(ren_ok),
    .ren_psrc1(ren_psrc1), .ren_psrc2(ren_psrc2), .ren_pdst(ren_pdst), .ren_pold(ren_pold),
    .ret_vld(ret_vld), .ret_arch(ret_arch), .ret_preg(ret_preg), .ret_free(ret_free)
  );

  int n_checks = 0;
  int n_fail = 0;
  int m_map[NARCH];
  int m_ret[NARCH];
  int m_free[$];
  bit recycled[NPHYS];
  inst_t inflight[$];
  string tag_override = "";
  int nret_drv = 0;

  task automatic check_eq(string tag, int act, int exp);
    string t;
    t = (tag_override != "") ? tag_override : tag;
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int a = 0; a < NARCH; a++) begin m_map[a] = a; m_ret[a] = a; end
    m_free.delete();
    for (int p = NARCH; p < NPHYS; p++) m_free.push_back(p);
    for (int p = 0; p < NPHYS; p++) recycled[p] = 1'b0;
    inflight.delete();
  endfunction

  // Compare outputs against a one-instruction-at-a-time model, then advance the model
  task automatic eval_and_update();
    int tmap[NARCH];
    bit grp[NARCH];
    int used;
    bit run;
    inst_t born[$];
    for (int a = 0; a < NARCH; a++) begin tmap[a] = m_map[a]; grp[a] = 1'b0; end
    used = 0;
    run = 1'b1;
    for (int i = 0; i < NW; i++) begin
      int s1, s2, d, en, need, en_t;
      s1 = int'(ren_src1[i*AW +: AW]);
      s2 = int'(ren_src2[i*AW +: AW]);
      d  = int'(ren_dst[i*AW +: AW]);
      en = int'(ren_dst_en[i]);
      need = (ren_vld[i] && en != 0 && d != 0) ? 1 : 0;
      if (!ren_vld[i] || flush) run = 1'b0;
      if (need != 0 && used >= m_free.size()) run = 1'b0;
      check_eq(flush ? "R8 accept" : "R6 accept", int'(ren_ok[i]), int'(run));
      if (run) begin
        check_eq(s1 == 0 ? "R5 src1" : (grp[s1] ? "R2 src1" : "R1 src1"),
                 int'(ren_psrc1[i*PW +: PW]), s1 == 0 ? 0 : tmap[s1]);
        check_eq(s2 == 0 ? "R5 src2" : (grp[s2] ? "R2 src2" : "R1 src2"),
                 int'(ren_psrc2[i*PW +: PW]), s2 == 0 ? 0 : tmap[s2]);
        if (need != 0) begin
          inst_t it;
          en_t = m_free[used];
          check_eq(recycled[en_t] ? "R7 recycled dst" : "R3 new dst",
                   int'(ren_pdst[i*PW +: PW]), en_t);
          check_eq(grp[d] ? "R2 old dst" : "R4 old dst", int'(ren_pold[i*PW +: PW]), tmap[d]);
          it.arch = d; it.newp = en_t; it.oldp = tmap[d];
          born.push_back(it);
          tmap[d] = en_t;
          grp[d] = 1'b1;
          used++;
        end else begin
          check_eq(en != 0 ? "R5 zero dst new" : "R3 no dst new", int'(ren_pdst[i*PW +: PW]), 0);
          check_eq(en != 0 ? "R5 zero dst old" : "R3 no dst old", int'(ren_pold[i*PW +: PW]), 0);
        end
      end
    end
    if (flush) begin
      bit busy[NPHYS];
      for (int p = 0; p < NPHYS; p++) busy[p] = 1'b0;
      for (int a = 0; a < NARCH; a++) begin m_map[a] = m_ret[a]; busy[m_ret[a]] = 1'b1; end
      m_free.delete();
      for (int p = 1; p < NPHYS; p++) begin
        if (!busy[p]) m_free.push_back(p);
        recycled[p] = 1'b0;
      end
      inflight.delete();
    end else begin
      for (int k = 0; k < used; k++) void'(m_free.pop_front());
      for (int b = 0; b < nret_drv; b++) begin
        inst_t r;
        r = inflight.pop_front();
        m_ret[r.arch] = r.newp;
        m_free.push_back(r.oldp);
        recycled[r.oldp] = 1'b1;
      end
      for (int a = 0; a < NARCH; a++) m_map[a] = tmap[a];
      foreach (born[k]) inflight.push_back(born[k]);
    end
  endtask

  task automatic drive_retire(int rmax);
    nret_drv = $urandom_range(0, rmax);
    if (nret_drv > inflight.size()) nret_drv = inflight.size();
    for (int b = 0; b < NB; b++) begin
      if (b < nret_drv) begin
        ret_vld[b] = 1'b1;
        ret_arch[b*AW +: AW] = AW'(inflight[b].arch);
        ret_preg[b*PW +: PW] = PW'(inflight[b].newp);
        ret_free[b*PW +: PW] = PW'(inflight[b].oldp);
      end else begin
        ret_vld[b] = 1'b0;
        ret_arch[b*AW +: AW] = AW'($urandom_range(0, NARCH - 1));
        ret_preg[b*PW +: PW] = PW'($urandom_range(1, NPHYS - 1));
        ret_free[b*PW +: PW] = PW'($urandom_range(1, NPHYS - 1));
      end
    end
  endtask

  task automatic random_cycle(int narrow, int rmax, int flush_pct, int hole_pct, int dst_pct);
    @(negedge clk);
    flush = ($urandom_range(0, 99) < flush_pct);
    for (int i = 0; i < NW; i++) begin
      ren_vld[i] = !($urandom_range(0, 99) < hole_pct);
      ren_src1[i*AW +: AW] = AW'($urandom_range(0, narrow));
      ren_src2[i*AW +: AW] = AW'($urandom_range(0, narrow));
      ren_dst[i*AW +: AW]  = AW'($urandom_range(0, narrow));
      ren_dst_en[i] = ($urandom_range(0, 99) < dst_pct);
    end
    drive_retire(rmax);
    #1;
    if (flush) nret_drv = 0;
    eval_and_update();
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state, every architectural number read once, then first allocations
    tag_override = "R9 reset state";
    for (int c = 0; c < NARCH / NW; c++) begin
      @(negedge clk);
      for (int i = 0; i < NW; i++) begin
        ren_vld[i] = 1'b1;
        ren_src1[i*AW +: AW] = AW'(c * NW + i);
        ren_src2[i*AW +: AW] = AW'(NARCH - 1 - (c * NW + i));
        ren_dst[i*AW +: AW] = '0;
        ren_dst_en[i] = 1'b0;
      end
      nret_drv = 0;
      ret_vld = '0;
      #1;
      eval_and_update();
    end
    @(negedge clk);
    for (int i = 0; i < NW; i++) begin
      ren_dst[i*AW +: AW] = AW'(i + 1);
      ren_dst_en[i] = 1'b1;
    end
    #1;
    eval_and_update();
    tag_override = "";
    for (int n = 0; n < 1500; n++) random_cycle(3, 4, 3, 0, 75);
    for (int n = 0; n < 600; n++)  random_cycle(3, 1, 1, 0, 90);
    for (int n = 0; n < 600; n++)  random_cycle(NARCH - 1, 4, 2, 15, 70);
    for (int n = 0; n < 300; n++)  random_cycle(2, 2, 10, 5, 100);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule